// File: doc/BRIEF.md
# Start-Condition Watchdog Timer

This block supervises a processor by watching a two-wire serial bus. Every bus start condition (the data line falling while the clock line is high) counts as a sign of life and restarts the watchdog count. If no start condition arrives before the selected period runs out, the block raises a one-cycle timeout request to the reset logic. After that request, the watchdog stays idle until a new start condition arrives.

The period comes from a small control register. The register holds a two-bit period selector and a lock-enable bit, and it is rewritten through a plain write strobe. The write-protect pin, together with the lock-enable bit, freezes the register. The count advances on a timebase tick taken from a prescaler of the system clock. The reset sequencer holds the counter cleared while reset is active. The register keeps its value through that reset and returns to its default only on power-on reset.

Top module: `sbus_wdt`

## Requirements
- R1: A start condition is recognized when the synchronized data line was 1 in the previous sample and is 0 in the current one, with the synchronized clock line 1 in both samples. Both lines pass through two flops, so a start condition driven on the pins takes effect at the third rising clock edge.
- R2: With the watchdog running, `tmo` goes high for exactly one clock cycle, TICK_DIV times the selected period in clock cycles after the edge that took effect for the last restart.
- R3: Period selector `cfg_q[1:0]`: 00 selects PER_SHORT, 01 selects PER_MID and 10 selects PER_LONG timebase ticks.
- R4: Period selector 11 disables the watchdog, so `tmo` stays low whatever the bus does.
- R5: A data-line fall while the clock line is low, and any data-line rise, do not restart the count.
- R6: A start condition before expiry restarts the full period.
- R7: After a timeout, `tmo` stays low until a new start condition rearms the watchdog.
- R8: While `sys_rst` is high, the count is held cleared, start conditions are ignored, `tmo` stays low, and `cfg_q` keeps its value. When `sys_rst` falls, an armed watchdog begins a full period.
- R9: A write stores `cfg_wdata` into `cfg_q` (bit 2 is the lock enable, bits 1:0 are the period). The write is ignored when `wp` is 1 and the stored lock-enable bit is 1.
- R10: An accepted write that changes the period restarts the count. A write of the same period leaves the count running.
- R11: Power-on reset (`por_n` low) sets `cfg_q` to 000, clears the count and arms the watchdog, so a full shortest period runs after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including the register |
| sys_rst | input | 1 | Reset held by the reset sequencer; clears the count, not the register |
| scl | input | 1 | Serial bus clock line |
| sda | input | 1 | Serial bus data line |
| wp | input | 1 | Write-protect pin |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Write data: bit 2 lock enable, bits 1:0 period |
| cfg_q | output | 3 | Current control register value |
| tmo | output | 1 | One-cycle timeout request to the reset logic |

## Verification
A fault in the counter, the prescaler or the period decode shows up at the ports as a timeout pulse that arrives early or late. The bench therefore times every pulse to the exact cycle after the third edge following the start condition. A bad arming flag shows up as a pulse during a long idle window or during a held reset, which is within a few hundred cycles of the stimulus. A fault in the write gating shows up one cycle after the strobe as a change in `cfg_q`, and it also shifts the next timeout.

// File: rtl/sbus_wdt.sv
module sbus_wdt #(
  parameter int TICK_DIV  = 8,
  parameter int PER_SHORT = 16,
  parameter int PER_MID   = 64,
  parameter int PER_LONG  = 256
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst,
  input  logic       scl,
  input  logic       sda,
  input  logic       wp,
  input  logic       cfg_we,
  input  logic [2:0] cfg_wdata,
  output logic [2:0] cfg_q,
  output logic       tmo
);
  localparam int PER_MAX = (PER_LONG > PER_MID) ? ((PER_LONG > PER_SHORT) ? PER_LONG : PER_SHORT)
                                                : ((PER_MID > PER_SHORT) ? PER_MID : PER_SHORT);
  localparam int CNT_W = $clog2(PER_MAX + 1);
  localparam int DIV_W = $clog2(TICK_DIV + 1);

  logic [2:0]       sda_sh, scl_sh;
  logic [CNT_W-1:0] cnt, limit;
  logic [DIV_W-1:0] pre;
  logic             armed;

  wire start   = sda_sh[2] & ~sda_sh[1] & scl_sh[2] & scl_sh[1];
  wire wr_ok   = cfg_we & ~(wp & cfg_q[2]);
  wire per_chg = wr_ok & (cfg_wdata[1:0] != cfg_q[1:0]);
  wire enabled = (cfg_q[1:0] != 2'b11);
  wire tick    = (pre == DIV_W'(TICK_DIV - 1));

  always_comb begin
    case (cfg_q[1:0])
      2'b00:   limit = CNT_W'(PER_SHORT);
      2'b01:   limit = CNT_W'(PER_MID);
      default: limit = CNT_W'(PER_LONG);
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sda_sh <= 3'b111;
      scl_sh <= 3'b111;
    end else begin
      sda_sh <= {sda_sh[1:0], sda};
      scl_sh <= {scl_sh[1:0], scl};
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q <= 3'b000;
      cnt   <= '0;
      pre   <= '0;
      armed <= 1'b1;
      tmo   <= 1'b0;
    end else begin
      tmo <= 1'b0;
      if (wr_ok) cfg_q <= cfg_wdata;
      if (sys_rst) begin
        cnt <= '0;
        pre <= '0;
      end else if (start) begin
        cnt   <= '0;
        pre   <= '0;
        armed <= 1'b1;
      end else if (per_chg) begin
        cnt <= '0;
        pre <= '0;
      end else if (armed && enabled) begin
        if (tick) begin
          pre <= '0;
          if (cnt == limit - CNT_W'(1)) begin
            cnt   <= '0;
            armed <= 1'b0;
            tmo   <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          pre <= pre + 1'b1;
        end
      end
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
    tmo |=> !tmo);
  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_q[1:0] == 2'b11) |=> !tmo);
  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> !tmo);
  a_r9_locked_write: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_we && wp && cfg_q[2]) |=> $stable(cfg_q));
  a_r6_kick_restart: assert property (@(posedge clk) disable iff (!por_n)
    (start && !sys_rst) |=> (cnt == '0 && armed));
  a_r7_disarm: assert property (@(posedge clk) disable iff (!por_n)
    tmo |-> !armed);
endmodule

// File: tb/sbus_wdt_test.sv
module sbus_wdt_test;
  localparam int DIV = 4, P0 = 3, P1 = 5, P2 = 8;

  logic clk = 1'b0, por_n = 1'b0, sys_rst = 1'b0, scl = 1'b1, sda = 1'b1, wp = 1'b0, cfg_we = 1'b0;
  logic [2:0] cfg_wdata = 3'b000;
  logic [2:0] cfg_q;
  logic tmo;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  sbus_wdt #(.TICK_DIV(DIV), .PER_SHORT(P0), .PER_MID(P1), .PER_LONG(P2)) uut (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .scl(scl), .sda(sda), .wp(wp),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .tmo(tmo));

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic kick();
    sda = 1'b0;
    @(negedge clk) scl = 1'b0;
    @(negedge clk) sda = 1'b1;
    @(negedge clk) scl = 1'b1;
  endtask

  task automatic wr(input logic [2:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk) cfg_we = 1'b0;
  endtask

  task automatic wait_tmo(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tmo && n < 1000);
  endtask

  task automatic quiet(input int cyc, output int hits);
    hits = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (tmo) hits++;
    end
  endtask

  int n, h;
  int pers[3] = '{P0, P1, P2};

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset cfg_q", int'(cfg_q), 0);
    chk("R11 reset tmo", int'(tmo), 0);
    por_n = 1'b1;
    wait_tmo(n);
    chk("R11 first period after power-on", n, P0 * DIV);
    @(negedge clk);
    chk("R2 pulse one cycle", int'(tmo), 0);
    quiet(150, h);
    chk("R7 no pulse while disarmed", h, 0);

    for (int s = 0; s < 3; s++) begin
      wr(3'(s));
      kick();
      wait_tmo(n);
      chk($sformatf("R3 R1 R2 period sel %0d", s), n, 3 + pers[s] * DIV - 3);
    end

    wr(3'b000);
    kick();
    repeat (6) @(negedge clk);
    kick();
    wait_tmo(n);
    chk("R6 restart by second start", n, P0 * DIV);

    kick();
    @(negedge clk) scl = 1'b0;
    @(negedge clk) sda = 1'b0;
    @(negedge clk) sda = 1'b1;
    @(negedge clk) scl = 1'b1;
    wait_tmo(n);
    chk("R5 data fall with clock low ignored", n, P0 * DIV - 4);

    wr(3'b011);
    kick();
    quiet(200, h);
    chk("R4 disabled no pulse", h, 0);
    wr(3'b000);
    wait_tmo(n);
    chk("R10 period change restarts", n, P0 * DIV);

    wr(3'b001);
    kick();
    repeat (5) @(negedge clk);
    wr(3'b001);
    wait_tmo(n);
    chk("R10 same period keeps count", n, P1 * DIV - 6);

    sys_rst = 1'b1;
    kick();
    quiet(100, h);
    chk("R8 no pulse in held reset", h, 0);
    chk("R8 register kept", int'(cfg_q), 1);
    sys_rst = 1'b0;
    quiet(100, h);
    chk("R8 start during reset ignored", h, 0);

    kick();
    repeat (7) @(negedge clk);
    sys_rst = 1'b1;
    repeat (3) @(negedge clk);
    sys_rst = 1'b0;
    wait_tmo(n);
    chk("R8 full period after release", n, P1 * DIV);

    wr(3'b100);
    chk("R9 write lock bit", int'(cfg_q), 4);
    wp = 1'b1;
    wr(3'b010);
    chk("R9 locked write ignored", int'(cfg_q), 4);
    kick();
    wait_tmo(n);
    chk("R9 locked period in effect", n, P0 * DIV);
    wp = 1'b0;
    wr(3'b110);
    chk("R9 unprotected write accepted", int'(cfg_q), 6);
    wr(3'b001);
    wp = 1'b1;
    wr(3'b010);
    chk("R9 lock bit clear allows write", int'(cfg_q), 2);
    wp = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule